// File: doc/BRIEF.md
# Video Beam Raster Counter

This block keeps track of where the beam is on a PAL raster. It counts an enabled pixel clock and groups every four pixel clocks into one memory-access slot. Slots are counted across a line and lines are counted across a frame. At each line end and each frame end it emits a single-cycle strobe. It also decodes the vertical blank, vertical sync and horizontal blank windows from the counters.

For a processor read, it packs the slot number and the line number into one 16-bit position word. The pixel-clock enable lets the surrounding chip run the block from a faster system clock. While the enable is low, nothing moves.

All geometry is set by parameters. The defaults are 227 slots of four pixel clocks per line (908 pixel clocks), 312 lines per frame, 29 blanked lines at the top of each frame, and horizontal blank ending at slot 43.

Top module: `beam_raster`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the pixel phase, slot and line outputs read 0 and every strobe reads 0.
- R2: Each clock with the enable high advances the pixel phase by one, from 0 to SLOT_CLKS-1 (default 3). The phase then returns to 0, and the slot number goes up by one in the same clock.
- R3: An enabled clock at slot LINE_SLOTS-1 (default 226) and the last phase sets the slot to 0 and increments the line. In the cycle that shows the new line, a one-cycle line strobe is high.
- R4: The same line-end clock, when taken on line FRAME_LINES-1 (default 311), sets the line to 0. A one-cycle frame strobe is high together with the line strobe.
- R5: The vertical blank flag is 1 exactly on lines 0 to VBLANK_LINES-1 (default 0..28).
- R6: The vertical sync flag is 1 on VSYNC_LINES (default 3) lines centred in the blank. It starts at line (VBLANK_LINES-VSYNC_LINES)/2, so the defaults give lines 13, 14 and 15.
- R7: The horizontal blank flag is 1 for slots below HBLANK_END_SLOT (default 43). When the slot becomes HBLANK_END_SLOT, a one-cycle blank-end strobe fires, and it fires exactly once per line.
- R8: The position word has the low 8 bits of the slot in bits 15:8 and the low 8 bits of the line in bits 7:0.
- R9: While the enable is low, the phase, slot and line hold their values and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock enable |
| pix_phase | output | PW | Pixel clock within the current slot |
| slot | output | SW | Access slot within the line |
| line | output | LW | Line within the frame |
| line_stb | output | 1 | One-cycle pulse at each new line |
| frame_stb | output | 1 | One-cycle pulse at each new frame |
| vblank | output | 1 | Vertical blank window |
| vsync | output | 1 | Vertical sync window |
| hblank | output | 1 | Horizontal blank window |
| hblank_end_stb | output | 1 | One-cycle pulse when horizontal blank ends |
| position | output | 16 | Packed slot/line readback word |

## Verification
The hardest conditions to reach are the frame wrap and the line numbers above 255. At the default geometry they sit about 283,000 enabled clocks after reset. The bench therefore drives a second instance with only eight slots per line and the default vertical geometry. Every one of its 312 lines is stepped through, checking the blank and sync windows, the packed line byte and the frame strobe at the wrap. A default-geometry instance covers the slot-level boundaries: the end of horizontal blank, slot 226 and the line strobe.

// File: rtl/beam_raster.sv
module beam_raster #(
  parameter int SLOT_CLKS       = 4,
  parameter int LINE_SLOTS      = 227,
  parameter int FRAME_LINES     = 312,
  parameter int VBLANK_LINES    = 29,
  parameter int VSYNC_LINES     = 3,
  parameter int HBLANK_END_SLOT = 43,
  localparam int PW = $clog2(SLOT_CLKS),
  localparam int SW = $clog2(LINE_SLOTS),
  localparam int LW = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  output logic [PW-1:0] pix_phase,
  output logic [SW-1:0] slot,
  output logic [LW-1:0] line,
  output logic          line_stb,
  output logic          frame_stb,
  output logic          vblank,
  output logic          vsync,
  output logic          hblank,
  output logic          hblank_end_stb,
  output logic [15:0]   position
);
  localparam int VS_FIRST = (VBLANK_LINES - VSYNC_LINES) / 2;

  logic end_slot, end_line, end_frame, hb_edge;

  assign end_slot  = pix_en && (pix_phase == PW'(SLOT_CLKS - 1));
  assign end_line  = end_slot && (slot == SW'(LINE_SLOTS - 1));
  assign end_frame = end_line && (line == LW'(FRAME_LINES - 1));
  assign hb_edge   = end_slot && (slot == SW'(HBLANK_END_SLOT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_phase      <= '0;
      slot           <= '0;
      line           <= '0;
      line_stb       <= 1'b0;
      frame_stb      <= 1'b0;
      hblank_end_stb <= 1'b0;
    end else begin
      line_stb       <= end_line;
      frame_stb      <= end_frame;
      hblank_end_stb <= hb_edge;
      if (pix_en) begin
        if (end_slot) begin
          pix_phase <= '0;
          if (end_line) begin
            slot <= '0;
            line <= end_frame ? '0 : line + 1'b1;
          end else begin
            slot <= slot + 1'b1;
          end
        end else begin
          pix_phase <= pix_phase + 1'b1;
        end
      end
    end
  end

  assign vblank   = line < LW'(VBLANK_LINES);
  assign vsync    = (line >= LW'(VS_FIRST)) && (line < LW'(VS_FIRST + VSYNC_LINES));
  assign hblank   = slot < SW'(HBLANK_END_SLOT);
  assign position = {8'(slot), 8'(line)};

  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && pix_phase == PW'(SLOT_CLKS - 1)) |=> (pix_phase == '0));

  assert_line_stb_at_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |-> (slot == '0 && pix_phase == '0));

  assert_frame_with_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> (line_stb && line == '0));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(slot) && $stable(line) && $stable(pix_phase) && !line_stb));

  assert_hblank_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_end_stb |-> (!hblank && $past(hblank)));
endmodule

// File: tb/beam_raster_tb.sv
module beam_raster_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  logic [1:0]  ph;
  logic [7:0]  sl;
  logic [8:0]  ln;
  logic        ls, fs, vb, vs, hb, he;
  logic [15:0] pos;

  beam_raster u_dut (.clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_phase(ph), .slot(sl),
    .line(ln), .line_stb(ls), .frame_stb(fs), .vblank(vb), .vsync(vs), .hblank(hb),
    .hblank_end_stb(he), .position(pos));

  logic [1:0]  f_ph;
  logic [2:0]  f_sl;
  logic [8:0]  f_ln;
  logic        f_ls, f_fs, f_vb, f_vs, f_hb, f_he;
  logic [15:0] f_pos;

  beam_raster #(.LINE_SLOTS(8), .HBLANK_END_SLOT(3)) u_frm (.clk(clk), .rst_n(rst_n),
    .pix_en(pix_en), .pix_phase(f_ph), .slot(f_sl), .line(f_ln), .line_stb(f_ls),
    .frame_stb(f_fs), .vblank(f_vb), .vsync(f_vs), .hblank(f_hb), .hblank_end_stb(f_he),
    .position(f_pos));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input bit en);
    pix_en = en;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(1'b1);
  endtask

  task automatic do_reset();
    pix_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 phase", int'(ph), 0);
    check("R1 slot", int'(sl), 0);
    check("R1 line", int'(ln), 0);
    check("R1 strobes", int'({ls, fs, he}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 line after release", int'(ln), 0);
  endtask

  task automatic test_phase_and_hold();
    tick(1'b1);
    check("R2 phase one", int'(ph), 1);
    run(3);
    check("R2 phase wrap", int'(ph), 0);
    check("R2 slot step", int'(sl), 1);
    for (int i = 0; i < 5; i++) begin
      tick(1'b0);
      check("R9 idle slot", int'(sl), 1);
      check("R9 idle phase", int'(ph), 0);
      check("R9 idle strobe", int'(ls), 0);
    end
  endtask

  task automatic test_hblank_edge();
    run(167);
    check("R7 slot 42", int'(sl), 42);
    check("R7 hblank high", int'(hb), 1);
    check("R7 no edge yet", int'(he), 0);
    tick(1'b1);
    check("R7 slot 43", int'(sl), 43);
    check("R7 hblank low", int'(hb), 0);
    check("R7 edge pulse", int'(he), 1);
    tick(1'b1);
    check("R7 edge ends", int'(he), 0);
    check("R8 position", int'(pos), 16'h2B00);
  endtask

  task automatic test_line_end();
    run(734);
    check("R3 slot 226", int'(sl), 226);
    check("R3 phase 3", int'(ph), 3);
    check("R3 no early strobe", int'(ls), 0);
    tick(1'b1);
    check("R3 slot zero", int'(sl), 0);
    check("R3 line one", int'(ln), 1);
    check("R3 line strobe", int'(ls), 1);
    check("R8 position new line", int'(pos), 16'h0001);
    tick(1'b1);
    check("R3 strobe single", int'(ls), 0);
  endtask

  task automatic test_pulses_per_line();
    int n_he = 0;
    int n_ls = 0;
    for (int i = 0; i < 908; i++) begin
      tick(1'b1);
      n_he += int'(he);
      n_ls += int'(ls);
    end
    check("R7 one edge per line", n_he, 1);
    check("R3 one strobe per line", n_ls, 1);
    check("R3 line two", int'(ln), 2);
  endtask

  task automatic test_frame();
    for (int l = 1; l <= 312; l++) begin
      run(32);
      check("R4 line count", int'(f_ln), l % 312);
      check("R3 line strobe small", int'(f_ls), 1);
      check("R4 frame strobe", int'(f_fs), (l == 312) ? 1 : 0);
      check("R5 vblank", int'(f_vb), ((l % 312) < 29) ? 1 : 0);
      check("R6 vsync", int'(f_vs), ((l % 312) >= 13 && (l % 312) <= 15) ? 1 : 0);
      check("R8 line byte", int'(f_pos[7:0]), (l % 312) & 255);
    end
    tick(1'b1);
    check("R4 frame strobe single", int'(f_fs), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    do_reset();
    test_phase_and_hold();
    test_hblank_edge();
    test_line_end();
    test_pulses_per_line();
    do_reset();
    test_frame();
    summary();
  end
endmodule